// File: doc/BRIEF.md
# Synthesizer Command Sequence Player

The block plays back a stored byte string of variable-length records and applies each record to an external frequency synthesizer. Each record starts with a length byte that counts the bytes after it, not itself. A length of two or more makes a register write: the first following byte is the register address, and the rest are that register's data. The player shifts all of these bytes out on a serial clock/data pair. A length of exactly one makes a single action code. That code can drive one of four control pins high or low, or stall playback until an external trigger rises or a ramp-done input is seen. This lets pin timing and trigger waits sit between the register writes in one sequence.

The byte store sits outside the block. It has a synchronous read port with one cycle of latency. Loading the store is done elsewhere. A start pulse runs the sequence from the current read position. Playback stops when the position reaches the end-of-data pointer. A rewind pulse stops any playback and returns to the first record without running it.

Top module: `seq_player`

## Requirements
- R1: A record is a length byte L followed by L bytes. When L is 2 or more, all L bytes after the length (address first, then the data in stored order) are shifted out serially, one byte after another. A record with L of 0 is passed over with no output.
- R2: Each serial byte is sent MSB first. SCLK runs at the clock divided by 4 and is high for 2 cycles of each bit. SDIO changes only while SCLK is low, and it is stable across every SCLK rising edge.
- R3: SCLK and SDIO stay low whenever no byte is being shifted, including whenever the player is not busy.
- R4: A one-byte action record with code 0x01 or 0x02 drives io_reset_o low or high. Codes 0x03/0x04 do the same for io_update_o, 0x05/0x06 for dr_hold_o, and 0x07/0x08 for dr_ctrl_o.
- R5: An action code that is not 0x01–0x08, 0xA4 or 0xA8 is skipped. It changes no pin and produces no serial traffic.
- R6: Action code 0xA4 stalls playback until the trigger input, after a two-flop synchronizer, rises after the wait began. A trigger that is already high when the wait begins does not release it.
- R7: Action code 0xA8 stalls playback while ramp_done_i is low, and playback resumes once it is high.
- R8: Playback stops when the read position reaches end_ptr_i. A start given at that position ends again at once with no output.
- R9: rewind_i stops playback within one cycle, keeps the pin levels, and moves the position to the first record without running. The next start replays from the first record.
- R10: busy_o rises only after a start pulse, and it stays high until playback stops.
- R11: After reset, all outputs are low and the read address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start playback pulse |
| rewind_i | input | 1 | Stop and return to the first record |
| end_ptr_i | input | AW+1 | Address one past the last stored byte |
| mem_addr_o | output | AW | Sequence store read address |
| mem_data_i | input | 8 | Read data, valid one cycle after the address |
| trig_i | input | 1 | Asynchronous trigger input |
| ramp_done_i | input | 1 | Ramp-finished level |
| busy_o | output | 1 | Playback in progress |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdio_o | output | 1 | Serial data to the synthesizer |
| io_reset_o | output | 1 | Serial port reset pin |
| io_update_o | output | 1 | Register update pin |
| dr_hold_o | output | 1 | Ramp hold pin |
| dr_ctrl_o | output | 1 | Ramp direction pin |

## Verification
The assertions check on every cycle that:
- SDIO moves only while SCLK is low and holds across each rising edge.
- Every SCLK high phase lasts exactly the divided half-period.
- The serial lines are quiet and the pins frozen whenever the player is idle.
- busy only rises after start, and a rewind stops playback.

Only the bench scenarios can show the byte order of register writes, the pin-to-code mapping, and the skipping of unknown codes. The same holds for the difference between a trigger edge and a trigger that is already high, the ramp stall, and the replay after a rewind. These are observed as an ordered stream of serial bytes and pin changes.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR_RD,
    S_HDR,
    S_BODY_RD,
    S_BODY,
    S_SHIFT,
    S_WTRIG,
    S_WRAMP
  } seq_state_e;

  localparam logic [7:0] ACT_WAIT_TRIG = 8'hA4;
  localparam logic [7:0] ACT_WAIT_RAMP = 8'hA8;
  localparam int unsigned NUM_PINS = 4;
endpackage

// File: rtl/seq_shift.sv
module seq_shift #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic       sclk_o,
  output logic       sdio_o
);
  localparam int unsigned PERIOD = 2 * DIV_HALF;
  localparam int unsigned PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(DIV_HALF);

  logic          act_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [PW-1:0] ph_q;
  logic          last_ph;

  assign last_ph = (ph_q == PH_LAST);
  assign done_o  = act_q && last_ph && (bit_q == 3'd7);
  assign sclk_o  = act_q && (ph_q >= PH_HIGH);
  assign sdio_o  = act_q && sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      bit_q <= '0;
      ph_q  <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      bit_q <= '0;
      ph_q  <= '0;
    end else if (load_i && !act_q) begin
      act_q <= 1'b1;
      sh_q  <= byte_i;
      bit_q <= '0;
      ph_q  <= '0;
    end else if (act_q) begin
      if (last_ph) begin
        ph_q  <= '0;
        sh_q  <= {sh_q[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) act_q <= 1'b0;
      end else begin
        ph_q <= ph_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/seq_trig.sv
module seq_trig #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic arm_i,
  input  logic wait_i,
  output logic hit_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            armed_q;
  logic            s;

  assign s     = sync_q[SYNC-1];
  assign hit_o = armed_q && wait_i && s && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], trig_i};
      prev_q <= s;
      if (arm_i)       armed_q <= 1'b1;
      else if (!wait_i) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_pins.sv
module seq_pins
  import seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [7:0]          code_i,
  output logic [NUM_PINS-1:0] pins_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [7:0] CODE_LO = 8'(2 * i + 1);
    localparam logic [7:0] CODE_HI = 8'(2 * i + 2);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pins_o[i] <= 1'b0;
      else if (set_i && code_i == CODE_LO)  pins_o[i] <= 1'b0;
      else if (set_i && code_i == CODE_HI)  pins_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_player.sv
module seq_player
  import seq_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned SYNC     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rewind_i,
  input  logic [AW:0]   end_ptr_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  input  logic          trig_i,
  input  logic          ramp_done_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          sdio_o,
  output logic          io_reset_o,
  output logic          io_update_o,
  output logic          dr_hold_o,
  output logic          dr_ctrl_o
);
  localparam logic [AW:0] PTR_ONE = (AW+1)'(1);

  seq_state_e          st_q;
  logic [AW:0]         ptr_q;
  logic [7:0]          len_q;
  logic                act_rec_q;
  logic                pin_set, sh_load, sh_done, trig_arm, trig_hit;
  logic [NUM_PINS-1:0] pins;

  assign mem_addr_o = ptr_q[AW-1:0];
  assign busy_o     = (st_q != S_IDLE);

  assign pin_set  = (st_q == S_BODY) && act_rec_q && !rewind_i;
  assign sh_load  = (st_q == S_BODY) && !act_rec_q && !rewind_i;
  assign trig_arm = pin_set && (mem_data_i == ACT_WAIT_TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ptr_q     <= '0;
      len_q     <= '0;
      act_rec_q <= 1'b0;
    end else if (rewind_i) begin
      st_q  <= S_IDLE;
      ptr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE:    if (start_i) st_q <= S_HDR_RD;
        S_HDR_RD:  st_q <= (ptr_q >= end_ptr_i) ? S_IDLE : S_HDR;
        S_HDR: begin
          len_q     <= mem_data_i;
          act_rec_q <= (mem_data_i == 8'd1);
          ptr_q     <= ptr_q + PTR_ONE;
          st_q      <= (mem_data_i == 8'd0) ? S_HDR_RD : S_BODY_RD;
        end
        S_BODY_RD: st_q <= S_BODY;
        S_BODY: begin
          ptr_q <= ptr_q + PTR_ONE;
          len_q <= len_q - 8'd1;
          if (act_rec_q) begin
            if (mem_data_i == ACT_WAIT_TRIG)      st_q <= S_WTRIG;
            else if (mem_data_i == ACT_WAIT_RAMP) st_q <= S_WRAMP;
            else                                  st_q <= S_HDR_RD;
          end else begin
            st_q <= S_SHIFT;
          end
        end
        S_SHIFT:   if (sh_done) st_q <= (len_q == 8'd0) ? S_HDR_RD : S_BODY_RD;
        S_WTRIG:   if (trig_hit) st_q <= S_HDR_RD;
        S_WRAMP:   if (ramp_done_i) st_q <= S_HDR_RD;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  seq_shift #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rewind_i),
    .load_i (sh_load),
    .byte_i (mem_data_i),
    .done_o (sh_done),
    .sclk_o (sclk_o),
    .sdio_o (sdio_o)
  );

  seq_trig #(.SYNC(SYNC)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .arm_i  (trig_arm),
    .wait_i (st_q == S_WTRIG),
    .hit_o  (trig_hit)
  );

  seq_pins u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pin_set),
    .code_i (mem_data_i),
    .pins_o (pins)
  );

  assign io_reset_o  = pins[0];
  assign io_update_o = pins[1];
  assign dr_hold_o   = pins[2];
  assign dr_ctrl_o   = pins[3];
endmodule

// File: rtl/seq_player_chk.sv
module seq_player_chk #(
  parameter int unsigned HALF = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rewind_i,
  input logic       busy_o,
  input logic       sclk_o,
  input logic       sdio_o,
  input logic [3:0] pins
);
  logic [7:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt_q <= '0;
    else if (sclk_o) hi_cnt_q <= hi_cnt_q + 8'd1;
    else             hi_cnt_q <= '0;
  end

  assert_sdio_hold_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdio_o));
  assert_sdio_moves_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdio_o) |-> !sclk_o);
  assert_sclk_high_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> hi_cnt_q < 8'(HALF));
  assert_sclk_high_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_cnt_q == 8'(HALF));
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sdio_o));
  assert_pins_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $stable(pins));
  assert_rewind_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> !busy_o);
  assert_busy_after_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind seq_player seq_player_chk #(.HALF(DIV_HALF)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rewind_i (rewind_i),
  .busy_o   (busy_o),
  .sclk_o   (sclk_o),
  .sdio_o   (sdio_o),
  .pins     ({dr_ctrl_o, dr_hold_o, io_update_o, io_reset_o})
);

// File: tb/seq_player_bench.sv
`timescale 1ns/1ps
module seq_player_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, rewind = 1'b0, trig = 1'b0, ramp_done = 1'b0;
  logic [AW:0]   end_ptr = 7'd21;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          busy, sclk, sdio, io_reset, io_update, dr_hold, dr_ctrl;
  logic [7:0]    mem [64];

  int checks = 0;
  int fails  = 0;
  logic [15:0] expq[$];
  logic [3:0]  mpins = 4'b0000;

  always #5 clk = ~clk;

  always_ff @(posedge clk) mem_data <= mem[mem_addr];

  seq_player u_seq_player (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rewind_i(rewind),
    .end_ptr_i(end_ptr), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .trig_i(trig), .ramp_done_i(ramp_done), .busy_o(busy),
    .sclk_o(sclk), .sdio_o(sdio), .io_reset_o(io_reset),
    .io_update_o(io_update), .dr_hold_o(dr_hold), .dr_ctrl_o(dr_ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected stream: {8'h01,byte} for serial bytes, {8'h02,code} for pin changes
  task automatic push_byte(input logic [7:0] b);
    expq.push_back({8'h01, b});
  endtask

  task automatic push_act(input logic [7:0] c);
    if (c >= 8'd1 && c <= 8'd8) begin
      int idx = (int'(c) - 1) / 2;
      logic v = ~c[0];
      if (mpins[idx] != v) begin
        mpins[idx] = v;
        expq.push_back({8'h02, c});
      end
    end
  endtask

  task automatic push_seg_a();
    push_byte(8'h07); push_byte(8'hA5); push_byte(8'h3C);
    push_act(8'h02); push_act(8'h04); push_act(8'h55);
  endtask
  task automatic push_seg_b(); push_act(8'h08); endtask
  task automatic push_seg_c();
    push_act(8'h03); push_byte(8'h0E); push_byte(8'h81);
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1 s = 1'b1;
    @(posedge clk); #1 s = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: turns outputs into events and compares with the expected queue
  logic       prev_sclk = 1'b0;
  logic [3:0] prev_pins = 4'b0000;
  logic [7:0] rx = '0;
  int         nbits = 0;

  task automatic observe(input logic [15:0] got);
    logic [15:0] exp;
    if (expq.size() == 0) begin
      chk(1'b0, (got[15:8] == 8'h01) ? "R1 unexpected byte" : "R5 unexpected pin change", got, 16'h0);
    end else begin
      exp = expq.pop_front();
      chk(got == exp, (exp[15:8] == 8'h01) ? "R1/R2 serial byte" : "R4 pin change", got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] cur;
      cur = {dr_ctrl, dr_hold, io_update, io_reset};
      if (sclk && !prev_sclk) begin
        rx = {rx[6:0], sdio};
        nbits++;
        if (nbits == 8) begin
          observe({8'h01, rx});
          nbits = 0;
        end
      end
      for (int i = 0; i < 4; i++)
        if (cur[i] != prev_pins[i]) observe({8'h02, 8'(2 * i + 1 + int'(cur[i]))});
      prev_sclk = sclk;
      prev_pins = cur;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    // write reg 0x07 with two data bytes
    mem[0]  = 8'h03; mem[1] = 8'h07; mem[2] = 8'hA5; mem[3] = 8'h3C;
    mem[4]  = 8'h01; mem[5]  = 8'h02;
    mem[6]  = 8'h01; mem[7]  = 8'h04;
    mem[8]  = 8'h01; mem[9]  = 8'h55;  // unknown code
    mem[10] = 8'h01; mem[11] = 8'hA4;  // wait trigger
    mem[12] = 8'h01; mem[13] = 8'h08;
    mem[14] = 8'h01; mem[15] = 8'hA8;  // wait ramp
    mem[16] = 8'h01; mem[17] = 8'h03;
    mem[18] = 8'h02; mem[19] = 8'h0E; mem[20] = 8'h81;

    wait_cyc(3);
    chk(!busy && !sclk && !sdio, "R11 reset outputs", {busy, sclk, sdio}, 0);
    chk({dr_ctrl, dr_hold, io_update, io_reset} == 4'b0, "R11 reset pins",
        {dr_ctrl, dr_hold, io_update, io_reset}, 0);
    chk(mem_addr == '0, "R11 reset address", mem_addr, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // run 1: stall at trigger wait
    push_seg_a();
    pulse(start);
    wait_cyc(400);
    chk(expq.size() == 0, "R1 bytes and pins before wait", expq.size(), 0);
    chk(busy, "R6 stalled at trigger wait", busy, 1);
    chk({dr_ctrl, dr_hold, io_update, io_reset} == 4'b0011, "R5 unknown code skipped",
        {dr_ctrl, dr_hold, io_update, io_reset}, 4'b0011);
    chk(!sclk && !sdio, "R3 serial lines idle during wait", {sclk, sdio}, 0);

    push_seg_b();
    #1 trig = 1'b1;
    wait_cyc(200);
    chk(expq.size() == 0, "R6 trigger edge released wait", expq.size(), 0);
    chk(busy, "R7 stalled at ramp wait", busy, 1);
    chk(dr_ctrl, "R4 dr_ctrl high", dr_ctrl, 1);

    push_seg_c();
    #1 ramp_done = 1'b1;
    wait_cyc(400);
    chk(expq.size() == 0, "R7 ramp done released wait", expq.size(), 0);
    chk(!busy, "R8 stopped at end pointer", busy, 0);
    chk(!sclk && !sdio, "R3 serial lines idle after stop", {sclk, sdio}, 0);

    // start at end: nothing happens
    pulse(start);
    wait_cyc(40);
    chk(!busy, "R8 start at end ends at once", busy, 0);
    chk(expq.size() == 0, "R8 no output at end", expq.size(), 0);

    // run 2: trigger already high at wait entry
    pulse(rewind);
    push_seg_a();
    pulse(start);
    wait_cyc(400);
    chk(expq.size() == 0, "R1 replay before wait", expq.size(), 0);
    chk(busy, "R6 high trigger does not release", busy, 1);

    pulse(rewind);
    wait_cyc(30);
    chk(!busy, "R9 rewind stops playback", busy, 0);
    chk({dr_ctrl, dr_hold, io_update, io_reset} == 4'b1011, "R9 pins kept on rewind",
        {dr_ctrl, dr_hold, io_update, io_reset}, 4'b1011);
    chk(mem_addr == '0, "R9 rewind to first record", mem_addr, 0);

    // run 3: replay from first record
    push_seg_a();
    pulse(start);
    wait_cyc(400);
    chk(expq.size() == 0, "R9 replay from first record", expq.size(), 0);
    chk(busy, "R10 busy during wait", busy, 1);
    #1 trig = 1'b0;
    wait_cyc(10);
    push_seg_b();
    push_seg_c();
    #1 trig = 1'b1;
    wait_cyc(500);
    chk(expq.size() == 0, "R1 full replay", expq.size(), 0);
    chk(!busy, "R8 stopped after replay", busy, 0);
    chk(io_update == 1'b0, "R4 io_update low", io_update, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule